// File: doc/BRIEF.md
# Windowed Watchdog with Escalating Recovery

This block supervises a periodic software activity through a refresh pulse. Time since the last reload is counted in ticks of a prescaled timebase. A refresh is accepted only while the tick count lies inside an open window set by a lower and an upper bound. A refresh that comes before the window opens, or after it closes, is a fault. So is the absence of any refresh once the count reaches the timeout bound. Every fault and every accepted refresh reloads the tick count, so the next window is always measured from the most recent event.

Faults that follow one another escalate. The first fault requests a restart of the stuck task. The second requests a warm reset that reinitialises peripherals. The third, and any fault after it, requests a cold reset, which is a full power cycle. Each request is a one-cycle pulse. The escalation level drops back to zero after a programmable number of accepted refreshes that come with no fault in between. A sticky cause field records why the most recent fault happened. If the window bounds are inconsistent, a flag is raised and built-in default bounds are used in their place.

Top module: `wwd_top`

## Requirements
- R1: After reset the three recovery pulses are low, `level_o` is 0, `cause_o` is 0 (none), and with consistent bounds `cfg_err_o` is low.
- R2: A refresh sampled while the tick count t satisfies lo <= t <= hi is accepted: no recovery pulse is produced, and the tick count restarts from zero, so a later refresh at the same offset is also accepted.
- R3: A refresh sampled while t < lo is an early fault, and it sets `cause_o` to 1.
- R4: A refresh sampled while hi < t < timeout is a late fault, and it sets `cause_o` to 2.
- R5: With no refresh, a timeout fault sets `cause_o` to 3. The fault pulse appears exactly PRESCALE*timeout+1 clock cycles after the reload and not earlier.
- R6: Each fault raises `level_o` by one, saturating at 3. The fault that moves the level to 1, 2 or 3 pulses `task_restart_o`, `warm_reset_o` or `cold_reset_o` respectively. At level 3, every further fault pulses `cold_reset_o` again.
- R7: At most one recovery output is high in any cycle. `task_restart_o` and `warm_reset_o` are never high for two cycles in a row.
- R8: After any fault the tick count restarts from zero, so the following window is measured from the fault.
- R9: When `calm_i` accepted refreshes follow one another with no fault in between, `level_o` returns to 0. A value of 0 acts like 1. A fault restarts this count.
- R10: When lo >= hi or hi > timeout, `cfg_err_o` is high and the default bounds (parameters DEF_LO, DEF_HI, DEF_TO) are used in place of the inputs.
- R11: `cause_o` changes only together with a recovery pulse. Accepted refreshes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| refresh_i | input | 1 | Refresh pulse from software, one cycle |
| lo_i | input | CNT_W | Tick count at which the window opens |
| hi_i | input | CNT_W | Last tick count at which a refresh is still accepted |
| timeout_i | input | CNT_W | Tick count at which a missing refresh becomes a fault |
| calm_i | input | CALM_W | Accepted refreshes needed to clear the escalation level |
| task_restart_o | output | 1 | One-cycle request to restart the stuck task |
| warm_reset_o | output | 1 | One-cycle warm-reset request |
| cold_reset_o | output | 1 | One-cycle cold-reset request |
| level_o | output | 2 | Current escalation level, 0 to 3 |
| cause_o | output | 2 | Cause of the latest fault: 0 none, 1 early, 2 late, 3 timeout |
| cfg_err_o | output | 1 | Bounds are inconsistent, so the defaults are in use |

## Verification
Refreshes are placed one tick below the lower bound, exactly on both bounds, one tick past the upper bound, and not at all. This separates the early, accepted, late and timeout outcomes at their edges, and it pins the timeout to one exact cycle. A chain of faults separated by accepted refreshes shows that the level steps up, saturates, and is cleared only by an unbroken run of accepted refreshes. Two kinds of inconsistent bounds are then applied, with refresh offsets chosen so that the input bounds and the default bounds would give different outcomes.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_EARLY   = 2'd1,
      CAUSE_LATE    = 2'd2,
      CAUSE_TIMEOUT = 2'd3
   } wwd_cause_e;

   localparam int unsigned WWD_LEVELS = 3;

endpackage

// File: rtl/wwd_tick.sv
// Prescaler: one tick every PRESCALE clocks, restarted by clr_i.
module wwd_tick #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   localparam int unsigned PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   initial begin
      if (PRESCALE < 2) $error("wwd_tick needs PRESCALE >= 2");
   end

   logic [PW-1:0] div_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 div_q <= '0;
      else if (clr_i || div_q == LAST) div_q <= '0;
      else                         div_q <= div_q + 1'b1;
   end

   assign tick_o = (div_q == LAST) && !clr_i;
endmodule

// File: rtl/wwd_window.sv
// Tick counter and classification of refreshes against the window.
module wwd_window
   import wwd_pkg::*;
#(
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned DEF_LO = 4,
   parameter int unsigned DEF_HI = 8,
   parameter int unsigned DEF_TO = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             refresh_i,
   input  logic [CNT_W-1:0] lo_i,
   input  logic [CNT_W-1:0] hi_i,
   input  logic [CNT_W-1:0] timeout_i,
   output logic             ok_o,
   output logic             fault_o,
   output wwd_cause_e       cause_o,
   output logic             reload_o,
   output logic             cfg_err_o
);
   localparam logic [CNT_W-1:0] D_LO = CNT_W'(DEF_LO);
   localparam logic [CNT_W-1:0] D_HI = CNT_W'(DEF_HI);
   localparam logic [CNT_W-1:0] D_TO = CNT_W'(DEF_TO);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lo_e, hi_e, to_e;
   logic             timed_out, early, late;

   // Select the bounds in use
   always_comb begin
      cfg_err_o = (lo_i >= hi_i) || (hi_i > timeout_i);
      if (cfg_err_o) begin
         lo_e = D_LO;
         hi_e = D_HI;
         to_e = D_TO;
      end else begin
         lo_e = lo_i;
         hi_e = hi_i;
         to_e = timeout_i;
      end
   end

   // Classify the current cycle; a timeout wins over a refresh in the same cycle
   always_comb begin
      timed_out = (cnt_q >= to_e);
      early     = refresh_i && (cnt_q < lo_e);
      late      = refresh_i && (cnt_q > hi_e);
      fault_o   = timed_out || early || late;
      ok_o      = refresh_i && !fault_o;
      if (timed_out)  cause_o = CAUSE_TIMEOUT;
      else if (early) cause_o = CAUSE_EARLY;
      else if (late)  cause_o = CAUSE_LATE;
      else            cause_o = CAUSE_NONE;
   end

   assign reload_o = ok_o || fault_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (reload_o) cnt_q <= '0;
      else if (tick_i)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wwd_escalate.sv
// Escalation level, calm-down counter, recovery pulses and sticky cause.
module wwd_escalate
   import wwd_pkg::*;
#(
   parameter int unsigned CALM_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ok_i,
   input  logic              fault_i,
   input  wwd_cause_e        cause_i,
   input  logic [CALM_W-1:0] calm_i,
   output logic [WWD_LEVELS-1:0] pulse_o,
   output logic [1:0]        level_o,
   output wwd_cause_e        cause_o
);
   logic [1:0]        level_q, level_n;
   logic [CALM_W-1:0] calm_q;
   logic [CALM_W:0]   calm_inc;
   logic [WWD_LEVELS-1:0] pulse_q;
   wwd_cause_e        cause_q;

   assign level_n  = (level_q == 2'd3) ? 2'd3 : level_q + 2'd1;
   assign calm_inc = {1'b0, calm_q} + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_q <= '0;
         calm_q  <= '0;
         cause_q <= CAUSE_NONE;
      end else if (fault_i) begin
         level_q <= level_n;
         calm_q  <= '0;
         cause_q <= cause_i;
      end else if (ok_i && level_q != 2'd0) begin
         if (calm_inc >= {1'b0, calm_i}) begin
            level_q <= '0;
            calm_q  <= '0;
         end else begin
            calm_q  <= calm_inc[CALM_W-1:0];
         end
      end
   end

   // One pulse register per recovery level
   for (genvar g = 0; g < WWD_LEVELS; g++) begin : g_pulse
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pulse_q[g] <= 1'b0;
         else         pulse_q[g] <= fault_i && (level_n == 2'(g + 1));
      end
   end

   assign pulse_o = pulse_q;
   assign level_o = level_q;
   assign cause_o = cause_q;
endmodule

// File: rtl/wwd_top.sv
module wwd_top
   import wwd_pkg::*;
#(
   parameter int unsigned PRESCALE = 1000,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned CALM_W   = 3,
   parameter int unsigned DEF_LO   = 4,
   parameter int unsigned DEF_HI   = 8,
   parameter int unsigned DEF_TO   = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              refresh_i,
   input  logic [CNT_W-1:0]  lo_i,
   input  logic [CNT_W-1:0]  hi_i,
   input  logic [CNT_W-1:0]  timeout_i,
   input  logic [CALM_W-1:0] calm_i,
   output logic              task_restart_o,
   output logic              warm_reset_o,
   output logic              cold_reset_o,
   output logic [1:0]        level_o,
   output logic [1:0]        cause_o,
   output logic              cfg_err_o
);
   initial begin
      if (PRESCALE < 1) $error("PRESCALE must be at least 1");
      if (CNT_W < 2 || CALM_W < 1) $error("counter widths too small");
      if (!(DEF_LO < DEF_HI && DEF_HI <= DEF_TO)) $error("default bounds inconsistent");
      if (DEF_TO >= (1 << CNT_W)) $error("DEF_TO does not fit CNT_W");
   end

   logic tick, ok, fault, reload;
   wwd_cause_e cause_now, cause_st;
   logic [WWD_LEVELS-1:0] pulses;

   if (PRESCALE == 1) begin : g_direct
      assign tick = 1'b1;
   end else begin : g_div
      wwd_tick #(.PRESCALE(PRESCALE)) i_tick (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (reload),
         .tick_o (tick)
      );
   end

   wwd_window #(
      .CNT_W (CNT_W),
      .DEF_LO(DEF_LO),
      .DEF_HI(DEF_HI),
      .DEF_TO(DEF_TO)
   ) i_window (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .refresh_i(refresh_i),
      .lo_i     (lo_i),
      .hi_i     (hi_i),
      .timeout_i(timeout_i),
      .ok_o     (ok),
      .fault_o  (fault),
      .cause_o  (cause_now),
      .reload_o (reload),
      .cfg_err_o(cfg_err_o)
   );

   wwd_escalate #(.CALM_W(CALM_W)) i_esc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ok_i   (ok),
      .fault_i(fault),
      .cause_i(cause_now),
      .calm_i (calm_i),
      .pulse_o(pulses),
      .level_o(level_o),
      .cause_o(cause_st)
   );

   assign task_restart_o = pulses[0];
   assign warm_reset_o   = pulses[1];
   assign cold_reset_o   = pulses[2];
   assign cause_o        = cause_st;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [CNT_W-1:0] lo_i,
   input logic [CNT_W-1:0] hi_i,
   input logic [CNT_W-1:0] timeout_i,
   input logic             task_restart_o,
   input logic             warm_reset_o,
   input logic             cold_reset_o,
   input logic [1:0]       level_o,
   input logic [1:0]       cause_o,
   input logic             cfg_err_o
);
   logic any_pulse;
   assign any_pulse = task_restart_o | warm_reset_o | cold_reset_o;

   p_one_action_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({task_restart_o, warm_reset_o, cold_reset_o}));

   p_task_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      task_restart_o |=> !task_restart_o);

   p_warm_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warm_reset_o |=> !warm_reset_o);

   p_task_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      task_restart_o |-> level_o == 2'd1);

   p_warm_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warm_reset_o |-> level_o == 2'd2);

   p_cold_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cold_reset_o |-> level_o == 2'd3);

   p_level_climb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o > $past(level_o)) |-> any_pulse);

   p_cause_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_pulse |-> $stable(cause_o));

   p_fault_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_pulse |-> cause_o != 2'd0);

   p_bad_bounds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((lo_i >= hi_i) || (hi_i > timeout_i)) |-> cfg_err_o);

   p_good_bounds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((lo_i < hi_i) && (hi_i <= timeout_i)) |-> !cfg_err_o);
endmodule

bind wwd_top wwd_checker #(.CNT_W(CNT_W)) i_wwd_checker (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .lo_i          (lo_i),
   .hi_i          (hi_i),
   .timeout_i     (timeout_i),
   .task_restart_o(task_restart_o),
   .warm_reset_o  (warm_reset_o),
   .cold_reset_o  (cold_reset_o),
   .level_o       (level_o),
   .cause_o       (cause_o),
   .cfg_err_o     (cfg_err_o)
);

// File: tb/test_wwd_top.sv
`timescale 1ns/1ps
module test_wwd_top;
   localparam int unsigned CNT_W  = 6;
   localparam int unsigned CALM_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic refresh = 1'b0;
   logic [CNT_W-1:0] lo = 6'd4, hi = 6'd8, tmo = 6'd12;
   logic [CALM_W-1:0] calm = 3'd2;
   logic t_o, w_o, c_o, cfg_err;
   logic [1:0] level, cause;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   wwd_top #(
      .PRESCALE(4), .CNT_W(CNT_W), .CALM_W(CALM_W),
      .DEF_LO(4), .DEF_HI(8), .DEF_TO(12)
   ) i_wwd_top (
      .clk_i(clk), .rst_ni(rst_n), .refresh_i(refresh),
      .lo_i(lo), .hi_i(hi), .timeout_i(tmo), .calm_i(calm),
      .task_restart_o(t_o), .warm_reset_o(w_o), .cold_reset_o(c_o),
      .level_o(level), .cause_o(cause), .cfg_err_o(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Compares all outputs; pulses packed as {cold,warm,task}
   task automatic expect_out(input string req, input int pulses, input int lvl, input int cs);
      int act_p;
      act_p = {c_o, w_o, t_o};
      chk(act_p == pulses, {req, " pulses"}, act_p, pulses);
      chk(level == 2'(lvl), {req, " level"}, level, lvl);
      if (cs >= 0) chk(cause == 2'(cs), {req, " cause"}, cause, cs);
   endtask

   // Waits c negedges after the last reload, then refreshes for one cycle.
   // Returns at the negedge right after the sampling edge.
   task automatic refresh_after(input int c);
      repeat (c) @(negedge clk);
      refresh = 1'b1;
      @(negedge clk);
      refresh = 1'b0;
   endtask

   task automatic t_reset;
      expect_out("R1 reset", 0, 0, 0);
      chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
   endtask

   task automatic t_valid;
      refresh_after(16);                 // t = 4 = lo
      expect_out("R2 on lower bound", 0, 0, 0);
      refresh_after(32);                 // t = 8 = hi, measured from reload
      expect_out("R2 on upper bound", 0, 0, 0);
   endtask

   task automatic t_early;
      refresh_after(15);                 // t = 3
      expect_out("R3 R6 early first fault", 1, 1, 1);
      @(negedge clk);
      expect_out("R7 pulse one cycle", 0, 1, 1);
   endtask

   task automatic t_late;
      refresh_after(35);                 // one negedge already spent: t = 9
      expect_out("R4 R6 R8 late second fault", 2, 2, 2);
   endtask

   task automatic t_timeout;
      repeat (48) @(negedge clk);
      expect_out("R5 not before timeout", 0, 2, 2);
      @(negedge clk);
      expect_out("R5 R6 timeout third fault", 4, 3, 3);
   endtask

   task automatic t_saturate;
      refresh_after(0);                  // t = 0 right after the timeout
      expect_out("R6 R8 saturated cold again", 4, 3, 1);
   endtask

   task automatic t_calm;
      refresh_after(16);
      expect_out("R9 R11 first calm refresh", 0, 3, 1);
      refresh_after(16);
      expect_out("R9 R11 level cleared", 0, 0, 1);
      refresh_after(2);
      expect_out("R6 fault after clear", 1, 1, 1);
      refresh_after(16);
      expect_out("R9 one calm refresh", 0, 1, 1);
      refresh_after(2);
      expect_out("R6 second fault", 2, 2, 1);
      refresh_after(16);
      expect_out("R9 fault restarted calm count", 0, 2, 1);
      refresh_after(16);
      expect_out("R9 cleared after two", 0, 0, 1);
   endtask

   task automatic t_calm_zero;
      calm = 3'd0;
      refresh_after(3);
      expect_out("R9 fault with calm zero", 1, 1, 1);
      refresh_after(16);
      expect_out("R9 calm zero clears at once", 0, 0, 1);
      calm = 3'd2;
   endtask

   task automatic t_cfg;
      lo = 6'd9; hi = 6'd5;
      #1;
      chk(cfg_err == 1'b1, "R10 lo above hi flagged", cfg_err, 1);
      refresh_after(16);                 // early under inputs, valid under defaults
      expect_out("R10 defaults lo/hi", 0, 0, 1);
      lo = 6'd4; hi = 6'd8; tmo = 6'd6;
      #1;
      chk(cfg_err == 1'b1, "R10 hi above timeout flagged", cfg_err, 1);
      refresh_after(24);                 // t = 6: would time out under inputs
      expect_out("R10 default timeout used", 0, 0, 1);
      refresh_after(36);                 // t = 9: late under defaults
      expect_out("R10 late under defaults", 1, 1, 2);
      tmo = 6'd12;
      #1;
      chk(cfg_err == 1'b0, "R10 consistent again", cfg_err, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_valid;
      t_early;
      t_late;
      t_timeout;
      t_saturate;
      t_calm;
      t_calm_zero;
      t_cfg;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule